// File: doc/BRIEF.md
# Sync-Gated Sample FIFO with Batch Interrupt

This block sits behind one decimation filter channel. It collects filter results in a small first-in first-out store so that the processor is interrupted once per batch of samples rather than once per sample. Each data-ready strobe carries one 32-bit result. A mode input selects whether that result is kept in full or narrowed to a sign-extended 16-bit value. The processor side sees the oldest word directly on the read port, takes it with a pop strobe, and can read the current fill level. A level-sensitive interrupt stays high while the fill level is at or above a programmable batch threshold.

An optional wait-for-sync mode arms the block so that it drops data-ready strobes until an external synchronisation pulse arrives. After that pulse, every strobe is stored. A flush empties the store and arms the wait again. Two sticky error flags record a write into a full store and a pop from an empty one. A dedicated clear input resets both flags.

Top module: `sfq_batch_fifo`

## Requirements
- R1: After a synchronous active-low reset, the block shows fill level 0, read data 0, interrupt low, both error flags low, and `sync_armed` equal to `sync_wait_en`.
- R2: Stored words come out in the order they were written. `rd_data` shows the oldest stored word. A pop removes that word and lowers the level by one, and each stored write raises the level by one.
- R3: A stored write into a full store (16 words) with no pop in the same cycle leaves the contents and the level unchanged and sets the sticky `ovf_flag`. `flag_clr` clears the flag one cycle later unless a new overflow happens in the same cycle, in which case the flag stays set.
- R4: While the store is empty, `rd_data` is 0. A pop on an empty store leaves the level at 0 and sets the sticky `udf_flag`, which `flag_clr` clears.
- R5: `irq` is high exactly when the level is at or above the effective threshold. The effective threshold is `batch_thresh` limited to the range 1 to 16: a value of 0 acts as 1, and any value above 16 acts as 16.
- R6: While `sync_wait_en` is 1 and the block is armed, data-ready strobes are dropped and the level does not change. A strobe in the same cycle as `sync_pulse` is stored.
- R7: A `sync_pulse` in a cycle without a flush disarms the block. From then on, every strobe is stored until the next flush.
- R8: `flush` empties the store in one cycle and re-arms the wait. A strobe or pop in the flush cycle has no effect and sets no error flag.
- R9: With `half_mode` = 1, the stored word is bits 15:0 of `wr_data` sign-extended to 32 bits. With `half_mode` = 0, all 32 bits are stored unchanged.
- R10: A pop and a stored write in the same cycle leave the level unchanged. This holds even when the store is full, and in that case no overflow is raised.
- R11: With `sync_wait_en` = 0, the armed state has no effect and every strobe is stored. `sync_armed` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_strobe | input | 1 | Data-ready strobe from the filter |
| wr_data | input | 32 | Filter result |
| half_mode | input | 1 | 1: store the sign-extended low 16 bits |
| sync_wait_en | input | 1 | Enables the wait-for-sync mode |
| sync_pulse | input | 1 | External synchronisation event |
| flush | input | 1 | Empties the store and re-arms the wait |
| pop | input | 1 | Takes the oldest word |
| flag_clr | input | 1 | Clears both sticky error flags |
| batch_thresh | input | 5 | Interrupt threshold in words |
| rd_data | output | 32 | Oldest stored word, or 0 when empty |
| level | output | 5 | Number of stored words |
| irq | output | 1 | Level-sensitive batch interrupt |
| ovf_flag | output | 1 | Sticky flag: write to a full store |
| udf_flag | output | 1 | Sticky flag: pop from an empty store |
| sync_armed | output | 1 | High while strobes are being dropped awaiting sync |

## Verification
The interesting collision is a stored write and a pop in the same cycle. When the store is full, this decides whether the word is taken or counted as an overflow, and when the store holds a single word, it decides what `rd_data` shows next. The random phases bias the pop rate high or low so that the store sits at full or empty for long stretches while strobes keep arriving. Directed steps also press a pop against a full store. Every cycle, a queue model in the bench predicts the level, the head word, the flags and the interrupt, and each of these is compared with the ports. A second collision, a sync pulse or a flush in the same cycle as a strobe, is driven on purpose and judged the same way.

// File: rtl/sfq_pkg.sv
// Package: shared widths and the word-narrowing helper for the sample FIFO.
// Assumes signed two's-complement filter results.
package sfq_pkg;

    localparam int unsigned SFQ_WORD_W = 32;
    localparam int unsigned SFQ_HALF_W = 16;

    typedef enum logic {
        SFQ_KEEP_FULL = 1'b0,
        SFQ_KEEP_HALF = 1'b1
    } sfq_width_e;

    // Sign-extend the low half of a word to the full width.
    function automatic logic [SFQ_WORD_W-1:0] sfq_narrow(input logic [SFQ_WORD_W-1:0] w);
        return {{(SFQ_WORD_W-SFQ_HALF_W){w[SFQ_HALF_W-1]}}, w[SFQ_HALF_W-1:0]};
    endfunction

endpackage

// File: rtl/sfq_arm.sv
// Module: wait-for-sync gate. Decides whether a data-ready strobe is kept.
// Assumes: reset and flush both arm it, and a sync pulse disarms it in the
// cycle it arrives, so a strobe in that same cycle is kept.
module sfq_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_en,
    input  logic sync_pulse,
    input  logic flush,
    input  logic strobe,
    output logic accept,
    output logic armed_o
);
    logic armed_q;

    // Armed state: set by reset or flush, cleared by a sync pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)          armed_q <= 1'b1;
        else if (flush)      armed_q <= 1'b1;
        else if (sync_pulse) armed_q <= 1'b0;
    end

    // Drop strobes only while the wait is enabled, armed and no sync is arriving.
    always_comb begin
        accept  = strobe & ~(wait_en & armed_q & ~sync_pulse);
        armed_o = wait_en & armed_q;
    end

    p_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> armed_q);
    p_disarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_pulse && !flush) |=> !armed_q);
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_pulse && !flush) |=> $stable(armed_q));

endmodule

// File: rtl/sfq_store.sv
// Module: circular word store with show-ahead read and fill counter.
// Assumes DEPTH is a power of two, so the pointers wrap on their own.
// A flush takes priority over any push or pop in the same cycle.
module sfq_store #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned WIDTH  = 32,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned LW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop_req,
    input  logic             flush,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    output logic [LW-1:0]    count,
    output logic             push_drop,
    output logic             pop_empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    rd_ptr;
    logic [AW-1:0]    wr_ptr;
    logic             full;
    logic             empty;
    logic             do_push;
    logic             do_pop;

    // Decode this cycle's push and pop and any error events.
    always_comb begin
        full      = (count == LW'(DEPTH));
        empty     = (count == '0);
        do_pop    = pop_req & ~empty & ~flush;
        do_push   = push_req & ~flush & (~full | do_pop);
        push_drop = push_req & ~flush & full & ~do_pop;
        pop_empty = pop_req & empty & ~flush;
        rdata     = empty ? '0 : mem[rd_ptr];
    end

    // Storage write, with no reset on the array.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Pointer and count update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LW'(DEPTH));
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_req && !pop_req && !flush) |=> (count == LW'(DEPTH)));
    p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop_req && !push_req && !flush) |=> (count == '0));
    p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));
    p_pushpop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req && !empty && !flush) |=> $stable(count));

endmodule

// File: rtl/sfq_flags.sv
// Module: sticky error flags and the batch interrupt compare.
// Assumes the threshold input may hold any value; it is limited to 1..DEPTH here.
// A new error event wins over a clear in the same cycle.
module sfq_flags #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ovf_evt,
    input  logic          udf_evt,
    input  logic          clr,
    input  logic [LW-1:0] fill,
    input  logic [LW-1:0] thresh,
    output logic          ovf,
    output logic          udf,
    output logic          irq
);
    logic [LW-1:0] thr_eff;

    // Limit the threshold to 1..DEPTH and compare it with the fill level.
    always_comb begin
        if (thresh == '0)                thr_eff = LW'(1);
        else if (thresh > LW'(DEPTH))    thr_eff = LW'(DEPTH);
        else                             thr_eff = thresh;
        irq = (fill >= thr_eff);
    end

    // Sticky flags: set by an event, cleared by clr when no event is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
            udf <= 1'b0;
        end else begin
            ovf <= ovf_evt | (ovf & ~clr);
            udf <= udf_evt | (udf & ~clr);
        end
    end

    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf);
    p_ovf_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !ovf_evt) |=> !ovf);
    p_udf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (udf && !clr) |=> udf);
    p_irq_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == '0) |-> !irq);
    p_irq_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == LW'(DEPTH)) |-> irq);

endmodule

// File: rtl/sfq_batch_fifo.sv
// Module: top of the sync-gated sample FIFO. It narrows incoming words,
// gates strobes through the wait-for-sync logic, stores them, and raises a
// level-sensitive interrupt once a batch has built up.
// Assumes the strobe, pop and control inputs are synchronous to clk.
module sfq_batch_fifo
    import sfq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_strobe,
    input  logic [SFQ_WORD_W-1:0] wr_data,
    input  logic                  half_mode,
    input  logic                  sync_wait_en,
    input  logic                  sync_pulse,
    input  logic                  flush,
    input  logic                  pop,
    input  logic                  flag_clr,
    input  logic [LW-1:0]         batch_thresh,
    output logic [SFQ_WORD_W-1:0] rd_data,
    output logic [LW-1:0]         level,
    output logic                  irq,
    output logic                  ovf_flag,
    output logic                  udf_flag,
    output logic                  sync_armed
);
    logic                  accept;
    logic                  push_drop;
    logic                  pop_empty;
    logic [SFQ_WORD_W-1:0] store_word;
    sfq_width_e            width_sel;

    // Choose between the full word and the sign-extended low half.
    always_comb begin
        width_sel  = sfq_width_e'(half_mode);
        store_word = (width_sel == SFQ_KEEP_HALF) ? sfq_narrow(wr_data) : wr_data;
    end

    sfq_arm u_arm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wait_en    (sync_wait_en),
        .sync_pulse (sync_pulse),
        .flush      (flush),
        .strobe     (wr_strobe),
        .accept     (accept),
        .armed_o    (sync_armed)
    );

    sfq_store #(.DEPTH(DEPTH), .WIDTH(SFQ_WORD_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (accept),
        .pop_req   (pop),
        .flush     (flush),
        .wdata     (store_word),
        .rdata     (rd_data),
        .count     (level),
        .push_drop (push_drop),
        .pop_empty (pop_empty)
    );

    sfq_flags #(.DEPTH(DEPTH)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .ovf_evt (push_drop),
        .udf_evt (pop_empty),
        .clr     (flag_clr),
        .fill    (level),
        .thresh  (batch_thresh),
        .ovf     (ovf_flag),
        .udf     (udf_flag),
        .irq     (irq)
    );

    p_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_armed && !sync_pulse && wr_strobe && !pop && !flush) |=> $stable(level));
    p_nowait_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_wait_en |-> !sync_armed);

endmodule

// File: tb/sfq_batch_fifo_test.sv
module sfq_batch_fifo_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_strobe = 0, half_mode = 0, sync_wait_en = 0, sync_pulse = 0;
    logic        flush = 0, pop = 0, flag_clr = 0;
    logic [31:0] wr_data = '0;
    logic [4:0]  batch_thresh = 5'd4;
    logic [31:0] rd_data;
    logic [4:0]  level;
    logic        irq, ovf_flag, udf_flag, sync_armed;

    int total = 0, bad = 0;
    bit finished = 0;

    logic [31:0] mq[$];
    bit m_armed = 1, m_ovf = 0, m_udf = 0;

    always #4 clk = ~clk;

    sfq_batch_fifo uut (
        .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .wr_data(wr_data),
        .half_mode(half_mode), .sync_wait_en(sync_wait_en), .sync_pulse(sync_pulse),
        .flush(flush), .pop(pop), .flag_clr(flag_clr), .batch_thresh(batch_thresh),
        .rd_data(rd_data), .level(level), .irq(irq), .ovf_flag(ovf_flag),
        .udf_flag(udf_flag), .sync_armed(sync_armed)
    );

    function automatic int eff_thr(input logic [4:0] t);
        if (t == 0) return 1;
        if (t > 16) return 16;
        return int'(t);
    endfunction

    function automatic logic [31:0] kept(input logic [31:0] d, input logic h);
        return h ? {{16{d[15]}}, d[15:0]} : d;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model step from the requirements; uses inputs before the edge.
    task automatic model_step();
        bit ovf_e = 0, udf_e = 0, pop_ok, acc;
        if (flush) begin
            mq.delete();
            m_armed = 1;                                  // R8
        end else begin
            pop_ok = pop && mq.size() > 0;
            udf_e  = pop && mq.size() == 0;               // R4
            acc    = wr_strobe && !(sync_wait_en && m_armed && !sync_pulse); // R6 R11
            if (sync_pulse) m_armed = 0;                  // R7
            if (pop_ok) void'(mq.pop_front());
            if (acc) begin
                if (mq.size() < 16) mq.push_back(kept(wr_data, half_mode)); // R9 R10
                else ovf_e = 1;                           // R3
            end
        end
        m_ovf = ovf_e | (m_ovf & !flag_clr);
        m_udf = udf_e | (m_udf & !flag_clr);
    endtask

    task automatic compare();
        chk("R2 level", 32'(level), 32'(mq.size()));
        chk("R2/R4 rd_data", rd_data, mq.size() > 0 ? mq[0] : 32'h0);
        chk("R5 irq", 32'(irq), 32'(mq.size() >= eff_thr(batch_thresh)));
        chk("R3 ovf_flag", 32'(ovf_flag), 32'(m_ovf));
        chk("R4 udf_flag", 32'(udf_flag), 32'(m_udf));
        chk("R6/R11 sync_armed", 32'(sync_armed), 32'(sync_wait_en & m_armed));
    endtask

    // One clock: drive at negedge, predict, wait an edge, compare at next negedge.
    task automatic step(input bit w, input logic [31:0] d, input bit p,
                        input bit s = 0, input bit f = 0, input bit c = 0);
        wr_strobe = w; wr_data = d; pop = p; sync_pulse = s; flush = f; flag_clr = c;
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 level", 32'(level), 0);
        chk("R1 rd_data", rd_data, 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 flags", {30'b0, ovf_flag, udf_flag}, 0);
        chk("R1 armed", 32'(sync_armed), 0);

        // R2 and R9: ordered storage, full and half words
        for (int i = 0; i < 3; i++) step(1, 32'hA000_0000 + i, 0);
        half_mode = 1;
        step(1, 32'h1234_8001, 0);
        step(1, 32'hFFFF_7FFE, 0);
        half_mode = 0;
        for (int i = 0; i < 3; i++) step(0, 0, 1);
        chk("R9 half negative", rd_data, 32'hFFFF_8001);
        step(0, 0, 1);
        chk("R9 half positive", rd_data, 32'h0000_7FFE);

        // R3: fill and overflow, R10: push and pop when full
        for (int i = 0; i < 18; i++) step(1, 32'hC000_0000 + i, 0);
        chk("R3 full level", 32'(level), 16);
        chk("R3 ovf set", 32'(ovf_flag), 1);
        step(1, 32'hD00D_0001, 1);
        chk("R10 level kept at full", 32'(level), 16);
        step(1, 32'hD00D_0002, 0, 0, 0, 1);
        chk("R3 set beats clear", 32'(ovf_flag), 1);
        step(0, 0, 0, 0, 0, 1);
        chk("R3 cleared", 32'(ovf_flag), 0);

        // R4: drain past empty
        for (int i = 0; i < 17; i++) step(0, 0, 1);
        chk("R4 udf set", 32'(udf_flag), 1);
        chk("R4 empty read zero", rd_data, 0);
        step(0, 0, 0, 0, 0, 1);

        // R5: threshold limits
        batch_thresh = 5'd0;  step(1, 32'h5, 0);
        chk("R5 zero acts as one", 32'(irq), 1);
        batch_thresh = 5'd31; step(0, 0, 0);
        chk("R5 above depth", 32'(irq), 0);
        batch_thresh = 5'd4;

        // R6 R7 R8: wait-for-sync
        sync_wait_en = 1;
        step(1, 32'h77, 1, 0, 1);
        chk("R8 flush empties", 32'(level), 0);
        for (int i = 0; i < 3; i++) step(1, 32'h100 + i, 0);
        chk("R6 armed drops", 32'(level), 0);
        step(1, 32'h200, 0, 1);
        chk("R6 sync-cycle strobe kept", 32'(level), 1);
        for (int i = 0; i < 3; i++) step(1, 32'h300 + i, 0);
        chk("R7 stored after sync", 32'(level), 4);
        step(1, 32'h400, 0, 1, 1);
        chk("R8 rearmed", 32'(sync_armed), 1);
        step(1, 32'h401, 0);
        chk("R8 drops after rearm", 32'(level), 0);

        // R11: wait disabled while armed
        sync_wait_en = 0;
        step(1, 32'h500, 0);
        chk("R11 stored when disabled", 32'(level), 1);

        // Random phases with the pop rate biased to reach full and empty
        for (int ph = 0; ph < 12; ph++) begin
            int pop_pct = (ph % 3 == 0) ? 10 : (ph % 3 == 1) ? 90 : 50;
            batch_thresh = 5'($urandom_range(0, 20));
            sync_wait_en = ($urandom_range(0, 1) == 1);
            half_mode    = ($urandom_range(0, 1) == 1);
            for (int i = 0; i < 250; i++)
                step($urandom_range(0, 99) < 70, $urandom,
                     $urandom_range(0, 99) < pop_pct,
                     $urandom_range(0, 99) < 3,
                     $urandom_range(0, 99) < 2,
                     $urandom_range(0, 99) < 4);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule